// File: doc/BRIEF.md
# Hybrid Update/Invalidate Coherence Line Controller

This block keeps the coherence state of a small array of cache lines for one cache on a snooping bus. The protocol mixes update and invalidate behaviour. A line that is filled by a local access enters the shared state, and local writes to it are broadcast as bus updates. Each line has its own saturating down-counter that is loaded with a threshold whenever the local processor touches the line. Every update snooped from another cache lowers the counter. A line that receives enough remote updates without any local use drops itself to invalid, so the cache stops holding a copy that nobody here reads.

The writer decides whether anyone else still holds the line when its update is granted on the bus. Every cache that keeps a valid copy after snooping an update drives a sharer signal, and the bus combines these signals with a wired-OR. If no sharer answers, the writer takes the line to modified, and later writes complete locally without bus traffic. A snooped read or update from another cache brings a modified line back to shared, so the next local write is broadcast again. Data storage, the arbiter and memory are outside this block.

Top module: `hyb_coh_ctrl`

## Requirements
- R1: After reset every line is invalid and `upd_req` is low. Line i's state is `line_state[2*i+1:2*i]` with the encoding invalid = 0, shared = 1, modified = 2.
- R2: A local read or write to an invalid line asserts `req_miss` in the same cycle. The line becomes shared with its counter at K, so it survives K-1 snooped updates and is invalidated by the K-th.
- R3: Any accepted local access to a valid line asserts `req_hit` and reloads that line's counter to K.
- R4: Each snooped update to a shared line lowers its counter by one. The update that takes the counter to zero makes the line invalid. `shr_out` is asserted in that cycle only if the line stays valid afterwards.
- R5: A local write to a shared or invalid line raises `upd_req` with `upd_line` naming the line on the next cycle. The request stays up, unchanged, until `upd_grant`. Local requests presented while it is up are ignored: they give no hit, no miss and no state change.
- R6: When the request is granted, a line that is still shared becomes modified if `shr_in` is low and stays shared if `shr_in` is high. `upd_req` drops after the grant.
- R7: A local write to a modified line reports a hit, keeps the line modified and raises no `upd_req`.
- R8: A snooped read or update to a modified line returns it to shared. A snooped update to a modified line asserts `shr_out`. The next local write to that line raises `upd_req` again.
- R9: A snooped update to an invalid line is ignored. The line stays invalid and `shr_out` stays low. A snooped read to an invalid line leaves it invalid.
- R10: When a local access and a snooped update target the same line in the same cycle, the local access wins. The counter ends at K, and `shr_out` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local processor access this cycle |
| req_write | input | 1 | Local access is a write |
| req_line | input | IDX_W | Line index of the local access |
| req_hit | output | 1 | Accepted local access found a valid line |
| req_miss | output | 1 | Accepted local access found an invalid line |
| snp_valid | input | 1 | Snooped bus transaction this cycle |
| snp_is_upd | input | 1 | Snooped transaction is an update (else a read) |
| snp_line | input | IDX_W | Line index of the snooped transaction |
| shr_out | output | 1 | This cache keeps a copy of the snooped updated line |
| shr_in | input | 1 | Wired-OR sharer signal of the other caches |
| upd_req | output | 1 | Bus-update request pending |
| upd_line | output | IDX_W | Line of the pending update |
| upd_grant | input | 1 | Bus grant for the pending update |
| line_state | output | 2*NUM_LINES | Packed per-line state |

## Verification
The bench builds the block with four lines and a threshold of 4. With that threshold the invalidation boundary is reached after four snooped updates, so both the last surviving update and the one that invalidates are checked. The same count exposes a counter that was not reloaded, or that was reloaded and then also decremented in the same cycle. Four lines let a write sit pending on one line while accesses to other lines, including the highest index, show that they are ignored or kept apart.

// File: rtl/hyb_coh_pkg.sv
package hyb_coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;
endpackage

// File: rtl/hyb_coh_line.sv
module hyb_coh_line
  import hyb_coh_pkg::*;
#(
  parameter int K     = 4,
  parameter int CNT_W = $clog2(K + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     loc_acc_i,
  input  logic     snp_upd_i,
  input  logic     snp_rd_i,
  input  logic     grant_i,
  input  logic     shr_i,
  output line_st_e st_o,
  output logic     keep_o
);
  localparam logic [CNT_W-1:0] KV  = CNT_W'(K);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  line_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  // grant first, then local access, then snoop
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (grant_i) begin
      if (st_q == LN_SHR && !shr_i) st_d = LN_MOD;
    end else if (loc_acc_i) begin
      cnt_d = KV;
      if (st_q == LN_INV) st_d = LN_SHR;
    end else if (snp_upd_i) begin
      case (st_q)
        LN_SHR: begin
          if (cnt_q <= ONE) begin
            cnt_d = '0;
            st_d  = LN_INV;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        LN_MOD:  st_d = LN_SHR;
        default: ;
      endcase
    end else if (snp_rd_i) begin
      if (st_q == LN_MOD) st_d = LN_SHR;
    end
  end

  assign en = grant_i | loc_acc_i | snp_upd_i | snp_rd_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_INV;
      cnt_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o   = st_q;
  assign keep_o = snp_upd_i && (st_q != LN_INV) &&
                  ((st_q == LN_MOD) || (cnt_q > ONE) || loc_acc_i);

  AST_INV_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_INV) |-> (cnt_q == '0)); // R4
  AST_LOCAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_acc_i && !grant_i) |=> (cnt_q == KV)); // R3
  AST_UPD_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_upd_i && !loc_acc_i && !grant_i && st_q == LN_SHR && cnt_q > ONE)
    |=> (cnt_q == $past(cnt_q) - ONE) && (st_q == LN_SHR)); // R4
  AST_INV_IGNORES_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_upd_i && !loc_acc_i && !grant_i && st_q == LN_INV) |=> (st_q == LN_INV)); // R9
  AST_LAST_HOLDER_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && st_q == LN_SHR && !shr_i) |=> (st_q == LN_MOD)); // R6
endmodule

// File: rtl/hyb_coh_pend.sv
module hyb_coh_pend #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_line_i,
  input  logic             grant_i,
  output logic             pend_o,
  output logic [IDX_W-1:0] line_o
);
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] line_q, line_d;

  always_comb begin
    pend_d = pend_q;
    line_d = line_q;
    if (pend_q && grant_i) begin
      pend_d = 1'b0;
    end else if (!pend_q && set_i) begin
      pend_d = 1'b1;
      line_d = set_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      line_q <= '0;
    end else begin
      pend_q <= pend_d;
      line_q <= line_d;
    end
  end

  assign pend_o = pend_q;
  assign line_o = line_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !grant_i) |=> (pend_q && $stable(line_q))); // R5
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && grant_i) |=> !pend_q); // R6
endmodule

// File: rtl/hyb_coh_ctrl.sv
module hyb_coh_ctrl
  import hyb_coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int K         = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [IDX_W-1:0]       req_line,
  output logic                   req_hit,
  output logic                   req_miss,
  input  logic                   snp_valid,
  input  logic                   snp_is_upd,
  input  logic [IDX_W-1:0]       snp_line,
  output logic                   shr_out,
  input  logic                   shr_in,
  output logic                   upd_req,
  output logic [IDX_W-1:0]       upd_line,
  input  logic                   upd_grant,
  output logic [2*NUM_LINES-1:0] line_state
);
  localparam int CNT_W = $clog2(K + 1);

  line_st_e             st_arr [NUM_LINES];
  logic [NUM_LINES-1:0] keep;
  logic                 pend, acc, set_pend;
  line_st_e             cur_st;

  assign acc      = req_valid && !pend;
  assign cur_st   = st_arr[req_line];
  assign req_hit  = acc && (cur_st != LN_INV);
  assign req_miss = acc && (cur_st == LN_INV);
  assign set_pend = acc && req_write && (cur_st != LN_MOD);

  hyb_coh_pend #(.IDX_W(IDX_W)) i_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_pend),
    .set_line_i (req_line),
    .grant_i    (upd_grant),
    .pend_o     (pend),
    .line_o     (upd_line)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic sel_req, sel_snp, sel_gnt;
    assign sel_req = acc && (req_line == IDX_W'(g));
    assign sel_snp = snp_valid && (snp_line == IDX_W'(g));
    assign sel_gnt = pend && upd_grant && (upd_line == IDX_W'(g));

    hyb_coh_line #(.K(K), .CNT_W(CNT_W)) i_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_acc_i (sel_req),
      .snp_upd_i (sel_snp && snp_is_upd),
      .snp_rd_i  (sel_snp && !snp_is_upd),
      .grant_i   (sel_gnt),
      .shr_i     (shr_in),
      .st_o      (st_arr[g]),
      .keep_o    (keep[g])
    );
    assign line_state[2*g +: 2] = st_arr[g];
  end

  assign shr_out = |keep;
  assign upd_req = pend;

  AST_MOD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !upd_req && req_write && cur_st == LN_MOD) |=> !upd_req); // R7
  AST_PEND_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> (!req_hit && !req_miss)); // R5
endmodule

// File: tb/test_hyb_coh_ctrl.sv
module test_hyb_coh_ctrl;
  localparam int NL = 4;
  localparam int KT = 4;
  localparam int IW = 2;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, snp_valid, snp_is_upd, shr_in, upd_grant;
  logic [IW-1:0] req_line, snp_line, upd_line;
  logic req_hit, req_miss, shr_out, upd_req;
  logic [2*NL-1:0] line_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hyb_coh_ctrl #(.NUM_LINES(NL), .K(KT)) i_hyb_coh_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_line(req_line),
    .req_hit(req_hit), .req_miss(req_miss),
    .snp_valid(snp_valid), .snp_is_upd(snp_is_upd), .snp_line(snp_line),
    .shr_out(shr_out), .shr_in(shr_in),
    .upd_req(upd_req), .upd_line(upd_line), .upd_grant(upd_grant),
    .line_state(line_state)
  );

  // ops: 0 idle, 1 read, 2 write, 3 snoop update, 4 snoop read, 5 grant (shr=sharer)
  // fields: op[15:13] line[12:11] shr[10] st[9:8] hit[7] miss[6] req[5] sh[4] rq[3:0]
  localparam logic [15:0] VEC [NV] = '{
    {3'd1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 read miss fills
    {3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 cnt 3
    {3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 cnt 2
    {3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 cnt 1
    {3'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 K-th update invalidates
    {3'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 update to invalid
    {3'd2, 2'd1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 write miss requests
    {3'd1, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 ignored while pending
    {3'd5, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 sharer stays S
    {3'd2, 2'd1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 write hit S
    {3'd5, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 last holder -> M
    {3'd2, 2'd1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 silent write
    {3'd4, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 snoop read M->S
    {3'd2, 2'd1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 updates again
    {3'd5, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {3'd3, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 snoop update M->S
    {3'd1, 2'd3, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 top line
    {3'd3, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
    {3'd3, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
    {3'd1, 2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 reload
    {3'd3, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},
    {3'd3, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},
    {3'd3, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 survives
    {3'd3, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 4th after reload
    {3'd4, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}   // R9 snoop read invalid
  };

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_line = '0;
    snp_valid = 0; snp_is_upd = 0; snp_line = '0;
    shr_in = 0; upd_grant = 0;
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] ln, input logic shr);
    idle_inputs();
    case (op)
      3'd1: begin req_valid = 1; req_line = ln; end
      3'd2: begin req_valid = 1; req_write = 1; req_line = ln; end
      3'd3: begin snp_valid = 1; snp_is_upd = 1; snp_line = ln; end
      3'd4: begin snp_valid = 1; snp_line = ln; end
      3'd5: begin upd_grant = 1; shr_in = shr; end
      default: ;
    endcase
  endtask

  task automatic chk(input int rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample combinational outputs, then registered ones
  task automatic step(input logic [2:0] op, input logic [1:0] ln, input logic shr,
                      input int rq, input int est, input int eh, input int em,
                      input int erq, input int esh);
    @(negedge clk);
    drive(op, ln, shr);
    #2;
    chk(rq, "hit", int'(req_hit), eh);
    chk(rq, "miss", int'(req_miss), em);
    chk(rq, "shr_out", int'(shr_out), esh);
    @(posedge clk);
    #2;
    chk(rq, "state", int'(line_state[2*ln +: 2]), est);
    chk(rq, "upd_req", int'(upd_req), erq);
    if (erq != 0) chk(rq, "upd_line", int'(upd_line), 1);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #2;
    chk(1, "reset state", int'(line_state), 0);       // R1
    chk(1, "reset upd_req", int'(upd_req), 0);        // R1
    @(negedge clk);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      e = VEC[v];
      step(e[15:13], e[12:11], e[10], int'(e[3:0]), int'(e[9:8]),
           int'(e[7]), int'(e[6]), int'(e[5]), int'(e[4]));
    end

    // R10: local read and snoop update to line 0 in the same cycle
    step(3'd1, 2'd0, 1'b0, 2, 1, 0, 1, 0, 0);          // R2 refill line 0
    @(negedge clk);
    drive(3'd1, 2'd0, 1'b0);
    snp_valid = 1; snp_is_upd = 1; snp_line = 2'd0;
    #2;
    chk(10, "hit", int'(req_hit), 1);                  // R10
    chk(10, "shr_out", int'(shr_out), 1);              // R10
    step(3'd3, 2'd0, 1'b0, 10, 1, 0, 0, 0, 1);
    step(3'd3, 2'd0, 1'b0, 10, 1, 0, 0, 0, 1);
    step(3'd3, 2'd0, 1'b0, 10, 1, 0, 0, 0, 1);         // R10 counter was K
    step(3'd3, 2'd0, 1'b0, 10, 0, 0, 0, 0, 0);

    // R1: reset in the middle of traffic with a pending request
    step(3'd2, 2'd1, 1'b0, 5, 1, 1, 0, 1, 0);
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    #2;
    chk(1, "async reset state", int'(line_state), 0); // R1
    chk(1, "async reset upd_req", int'(upd_req), 0);  // R1
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule